// File: doc/BRIEF.md
# Boot-Window Command Sequencer

This block sits behind the boot-buffer address window of a flash device and turns single command words written there into device actions. A boot ROM can use it to warm-reset the device, to drop the identification bytes into the first words of the boot buffer, or to pull pages one at a time into data buffer 0. None of these needs the main register file.

A page load takes two writes. First the arming word is written, then the go word. Once the back end acknowledges a load, the block's page-address register advances by 4. Repeating the two-write pair therefore walks through consecutive pages. The flash read itself is done by an external engine through a request/acknowledge handshake. While a load request or an identification sequence is in progress, the block deasserts its ready signal and ignores new writes.

The state machine has six states:

- ST_IDLE waits for a command.
- ST_ARMED waits for the second write of a load.
- ST_ID0, ST_ID1 and ST_ID2 emit the three identification writes, one per cycle.
- ST_LOAD holds the load request.

It has these transitions:

- From ST_IDLE, the arming word leads to ST_ARMED, and the identify word leads to ST_ID0. The reset word and unknown words leave the state in ST_IDLE.
- From ST_ARMED, any accepted write leads back to ST_IDLE, except the go word, which leads to ST_LOAD.
- ST_ID0 leads to ST_ID1, then to ST_ID2, then to ST_IDLE, without conditions.
- ST_LOAD leads to ST_IDLE when the acknowledge arrives.

Top module: `boot_cmd_seq`

## Requirements
- R1: A write is seen only when `wr_en` is high, `wr_rdy` is high and `wr_addr` lies in 0x0000..0x01FF or 0x8000..0x800F. A write at any other address has no effect on state or outputs.
- R2: In ST_IDLE, a seen write of 0x00F0 raises `warm_rst` for exactly one cycle, in the cycle after the write, and leaves the block idle.
- R3: In ST_IDLE, a seen write of 0x00E0 arms the block. The next seen write of 0x0000 raises `ld_req`, and `ld_req` then stays high, with `ld_sec` stable, until `ld_ack` is sampled high.
- R4: When the block is armed, the next seen write is consumed whatever its value. If that value is not 0x0000, no load, reset or error strobe follows, and the block returns to ST_IDLE.
- R5: `ld_sec` equals (((page bits 7:2) + (blk << 6)) << 2) + page bits 1:0. Here blk is `blk_addr` bits 11:0, ORed with the density mask (default 0x1000) when `blk_addr` bit 15 is set. The page value used is the one current at the go write.
- R6: On a cycle with `ld_req` and `ld_ack` both high, `page_addr` gains 4, modulo 256.
- R7: In ST_IDLE, a seen write of 0x0090 produces three consecutive `id_wr_en` cycles with `id_wr_idx` 0, 1 and 2. The data on these cycles is {8'h00, low byte of `man_id`}, then {8'h00, low byte of `dev_id`}, then {8'h00, low byte of `wp_stat`}.
- R8: In ST_IDLE, any other seen value pulses `bad_cmd` for one cycle and has no other effect.
- R9: `wr_rdy` is low in ST_LOAD and in ST_ID0..ST_ID2. Writes presented while `wr_rdy` is low are ignored.
- R10: After reset, the block is in ST_IDLE with `wr_rdy` high, `page_addr` 0, and every request and strobe low.
- R11: `pg_set` loads `pg_set_val` into `page_addr` on the next edge and takes priority over the step of R6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 16 | Word offset of the write |
| wr_data | input | 16 | Written command word |
| wr_rdy | output | 1 | Block can take a write |
| blk_addr | input | 16 | Block-number register value |
| pg_set | input | 1 | Load the page register |
| pg_set_val | input | 8 | Value for the page register |
| page_addr | output | 8 | Page-address register |
| man_id | input | 16 | Manufacturer identifier |
| dev_id | input | 16 | Device identifier |
| wp_stat | input | 16 | Write-protection status |
| id_wr_en | output | 1 | Boot-buffer word write request |
| id_wr_idx | output | 2 | Boot-buffer word index |
| id_wr_data | output | 16 | Boot-buffer word data |
| ld_req | output | 1 | Page-load request to buffer 0 |
| ld_sec | output | 21 | Sector address of the load |
| ld_ack | input | 1 | Back end has taken the load |
| warm_rst | output | 1 | One-cycle warm-reset pulse |
| bad_cmd | output | 1 | One-cycle unknown-command strobe |

## Verification
There are two ways for the state to go wrong, and each shows at the ports:

- A block stuck in ST_ARMED turns the next reset word into a silent no-op: `warm_rst` stays low where a pulse was due one cycle after the write. A block that falls out of ST_ARMED too early raises `bad_cmd` on the go word.
- A lost or early exit from ST_LOAD shows as `ld_req` dropping before the acknowledge, or `wr_rdy` rising while the request is still pending. A wrong page step shows on `page_addr` one cycle after the acknowledge.

The identification sequence is checked index by index, so a skipped or repeated state shows in the very cycle it occurs.

// File: rtl/boot_seq_pkg.sv
package boot_seq_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ARMED,
        ST_ID0,
        ST_ID1,
        ST_ID2,
        ST_LOAD
    } seq_state_e;

    localparam logic [15:0] CMD_RESET = 16'h00F0;
    localparam logic [15:0] CMD_ARM   = 16'h00E0;
    localparam logic [15:0] CMD_IDENT = 16'h0090;
    localparam logic [15:0] CMD_GO    = 16'h0000;
endpackage

// File: rtl/boot_win_decode.sv
module boot_win_decode #(
    parameter int          ADDR_W = 16,
    parameter logic [15:0] W0_LO  = 16'h0000,
    parameter logic [15:0] W0_HI  = 16'h01FF,
    parameter logic [15:0] W1_LO  = 16'h8000,
    parameter logic [15:0] W1_HI  = 16'h800F
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              hit
);
    logic in_w0;
    logic in_w1;

    always_comb begin
        in_w0 = (addr >= ADDR_W'(W0_LO)) && (addr <= ADDR_W'(W0_HI));
        in_w1 = (addr >= ADDR_W'(W1_LO)) && (addr <= ADDR_W'(W1_HI));
        hit   = in_w0 || in_w1;
    end
endmodule

// File: rtl/boot_sec_calc.sv
module boot_sec_calc #(
    parameter int              REG_W        = 16,
    parameter int              BLK_LOW_W    = 12,
    parameter int              BLK_W        = 13,
    parameter int              PG_W         = 8,
    parameter logic [BLK_W-1:0] DENSITY_MASK = 13'h1000,
    parameter int              SEC_W        = BLK_W + PG_W
) (
    input  logic [REG_W-1:0] blk,
    input  logic [PG_W-1:0]  pg,
    output logic [SEC_W-1:0] sec
);
    logic [BLK_W-1:0] blk_num;
    logic [SEC_W-1:0] page_blk_sum;

    always_comb begin
        blk_num      = BLK_W'(blk[BLK_LOW_W-1:0]) | (blk[REG_W-1] ? DENSITY_MASK : '0);
        page_blk_sum = SEC_W'(pg[PG_W-1:2]) + (SEC_W'(blk_num) << 6);
        sec          = (page_blk_sum << 2) + SEC_W'(pg[1:0]);
    end
endmodule

// File: rtl/boot_page_reg.sv
module boot_page_reg #(
    parameter int PG_W = 8,
    parameter int STEP = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            set,
    input  logic [PG_W-1:0] set_val,
    input  logic            step,
    output logic [PG_W-1:0] q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else if (set) begin
            q <= set_val;
        end else if (step) begin
            q <= q + PG_W'(STEP);
        end
    end
endmodule

// File: rtl/boot_cmd_seq.sv
module boot_cmd_seq
    import boot_seq_pkg::*;
#(
    parameter int               ADDR_W       = 16,
    parameter int               REG_W        = 16,
    parameter int               PG_W         = 8,
    parameter int               BLK_LOW_W    = 12,
    parameter int               BLK_W        = 13,
    parameter logic [BLK_W-1:0] DENSITY_MASK = 13'h1000,
    parameter int               PG_STEP      = 4,
    parameter int               SEC_W        = BLK_W + PG_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [REG_W-1:0]  wr_data,
    output logic              wr_rdy,
    input  logic [REG_W-1:0]  blk_addr,
    input  logic              pg_set,
    input  logic [PG_W-1:0]   pg_set_val,
    output logic [PG_W-1:0]   page_addr,
    input  logic [REG_W-1:0]  man_id,
    input  logic [REG_W-1:0]  dev_id,
    input  logic [REG_W-1:0]  wp_stat,
    output logic              id_wr_en,
    output logic [1:0]        id_wr_idx,
    output logic [REG_W-1:0]  id_wr_data,
    output logic              ld_req,
    output logic [SEC_W-1:0]  ld_sec,
    input  logic              ld_ack,
    output logic              warm_rst,
    output logic              bad_cmd
);
    localparam int BYTE_W = 8;

    seq_state_e       state_q, state_d;
    logic             win_hit;
    logic             wr_take;
    logic             go_take;
    logic [SEC_W-1:0] sec_now;
    logic [SEC_W-1:0] sec_q;
    logic             pg_step;

    boot_win_decode #(.ADDR_W(ADDR_W)) u_dec (
        .addr (wr_addr),
        .hit  (win_hit)
    );

    boot_sec_calc #(
        .REG_W        (REG_W),
        .BLK_LOW_W    (BLK_LOW_W),
        .BLK_W        (BLK_W),
        .PG_W         (PG_W),
        .DENSITY_MASK (DENSITY_MASK),
        .SEC_W        (SEC_W)
    ) u_sec (
        .blk (blk_addr),
        .pg  (page_addr),
        .sec (sec_now)
    );

    boot_page_reg #(.PG_W(PG_W), .STEP(PG_STEP)) u_pg (
        .clk     (clk),
        .rst_n   (rst_n),
        .set     (pg_set),
        .set_val (pg_set_val),
        .step    (pg_step),
        .q       (page_addr)
    );

    assign wr_take = wr_en && win_hit && wr_rdy;
    assign go_take = (state_q == ST_ARMED) && wr_take && (wr_data == CMD_GO);
    assign pg_step = (state_q == ST_LOAD) && ld_ack;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (wr_take) begin
                    case (wr_data)
                        CMD_ARM:   state_d = ST_ARMED;
                        CMD_IDENT: state_d = ST_ID0;
                        default:   state_d = ST_IDLE;
                    endcase
                end
            end
            ST_ARMED: begin
                if (wr_take) state_d = (wr_data == CMD_GO) ? ST_LOAD : ST_IDLE;
            end
            ST_ID0:  state_d = ST_ID1;
            ST_ID1:  state_d = ST_ID2;
            ST_ID2:  state_d = ST_IDLE;
            ST_LOAD: begin
                if (ld_ack) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state-derived outputs
    always_comb begin
        wr_rdy     = 1'b0;
        id_wr_en   = 1'b0;
        id_wr_idx  = 2'd0;
        id_wr_data = '0;
        ld_req     = 1'b0;
        unique case (state_q)
            ST_IDLE, ST_ARMED: wr_rdy = 1'b1;
            ST_ID0: begin
                id_wr_en   = 1'b1;
                id_wr_idx  = 2'd0;
                id_wr_data = REG_W'(man_id[BYTE_W-1:0]);
            end
            ST_ID1: begin
                id_wr_en   = 1'b1;
                id_wr_idx  = 2'd1;
                id_wr_data = REG_W'(dev_id[BYTE_W-1:0]);
            end
            ST_ID2: begin
                id_wr_en   = 1'b1;
                id_wr_idx  = 2'd2;
                id_wr_data = REG_W'(wp_stat[BYTE_W-1:0]);
            end
            ST_LOAD: ld_req = 1'b1;
            default: wr_rdy = 1'b0;
        endcase
    end

    // registered strobes and latched sector
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            warm_rst <= 1'b0;
            bad_cmd  <= 1'b0;
            sec_q    <= '0;
        end else begin
            warm_rst <= (state_q == ST_IDLE) && wr_take && (wr_data == CMD_RESET);
            bad_cmd  <= (state_q == ST_IDLE) && wr_take &&
                        (wr_data != CMD_RESET) && (wr_data != CMD_ARM) &&
                        (wr_data != CMD_IDENT);
            if (go_take) sec_q <= sec_now;
        end
    end

    assign ld_sec = sec_q;
endmodule

// File: rtl/boot_cmd_seq_chk.sv
module boot_cmd_seq_chk #(
    parameter int PG_W  = 8,
    parameter int SEC_W = 21
) (
    input logic            clk,
    input logic            rst_n,
    input logic            wr_rdy,
    input logic            ld_req,
    input logic            ld_ack,
    input logic [SEC_W-1:0] ld_sec,
    input logic [PG_W-1:0] page_addr,
    input logic            pg_set,
    input logic            warm_rst,
    input logic            bad_cmd,
    input logic            id_wr_en,
    input logic [1:0]      id_wr_idx
);
    a_r3_req_held: assert property (@(posedge clk) disable iff (!rst_n)
        ld_req && !ld_ack |=> ld_req && $stable(ld_sec));

    a_r9_stall_load: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_req || id_wr_en) |-> !wr_rdy);

    a_r2_rst_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        warm_rst |=> !warm_rst);

    a_r8_bad_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        bad_cmd |=> !bad_cmd);

    a_r6_page_step: assert property (@(posedge clk) disable iff (!rst_n)
        ld_req && ld_ack && !pg_set |=> page_addr == PG_W'($past(page_addr) + PG_W'(4)));

    a_r7_id_order: assert property (@(posedge clk) disable iff (!rst_n)
        id_wr_en && id_wr_idx != 2'd2 |=> id_wr_en && id_wr_idx == 2'($past(id_wr_idx) + 2'd1));

    a_r7_id_end: assert property (@(posedge clk) disable iff (!rst_n)
        id_wr_en && id_wr_idx == 2'd2 |=> !id_wr_en && wr_rdy);
endmodule

bind boot_cmd_seq boot_cmd_seq_chk #(.PG_W(PG_W), .SEC_W(SEC_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_rdy    (wr_rdy),
    .ld_req    (ld_req),
    .ld_ack    (ld_ack),
    .ld_sec    (ld_sec),
    .page_addr (page_addr),
    .pg_set    (pg_set),
    .warm_rst  (warm_rst),
    .bad_cmd   (bad_cmd),
    .id_wr_en  (id_wr_en),
    .id_wr_idx (id_wr_idx)
);

// File: tb/sim_boot_cmd_seq.sv
module sim_boot_cmd_seq;
    localparam int CLK_PERIOD = 10;
    localparam int SEC_W = 21;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             wr_en = 1'b0;
    logic [15:0]      wr_addr = '0;
    logic [15:0]      wr_data = '0;
    logic             wr_rdy;
    logic [15:0]      blk_addr = '0;
    logic             pg_set = 1'b0;
    logic [7:0]       pg_set_val = '0;
    logic [7:0]       page_addr;
    logic [15:0]      man_id = 16'hABCD;
    logic [15:0]      dev_id = 16'h1234;
    logic [15:0]      wp_stat = 16'h0002;
    logic             id_wr_en;
    logic [1:0]       id_wr_idx;
    logic [15:0]      id_wr_data;
    logic             ld_req;
    logic [SEC_W-1:0] ld_sec;
    logic             ld_ack = 1'b0;
    logic             warm_rst;
    logic             bad_cmd;

    int total = 0;
    int bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    boot_cmd_seq u0 (.*);

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_sec(input logic [15:0] blk, input logic [7:0] pg);
        int bn;
        bn = int'(blk[11:0]) | (blk[15] ? 32'h1000 : 32'h0);
        return 32'(((int'(pg >> 2) + (bn << 6)) << 2) + int'(pg[1:0]));
    endfunction

    task automatic wr(input logic [15:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_addr = 16'h4000; wr_data = 16'hFFFF;
    endtask

    task automatic set_page(input logic [7:0] v);
        @(negedge clk);
        pg_set = 1'b1; pg_set_val = v;
        @(negedge clk);
        pg_set = 1'b0;
    endtask

    task automatic ack_load();
        ld_ack = 1'b1;
        @(negedge clk);
        ld_ack = 1'b0;
    endtask

    task automatic t_reset();
        chk("R10 rdy", 32'(wr_rdy), 1);
        chk("R10 page", 32'(page_addr), 0);
        chk("R10 req", 32'({ld_req, id_wr_en, warm_rst, bad_cmd}), 0);
    endtask

    task automatic t_warm();
        wr(16'h0010, 16'h00F0);
        chk("R2 pulse", 32'(warm_rst), 1);
        @(negedge clk);
        chk("R2 one cycle", 32'(warm_rst), 0);
        chk("R2 idle", 32'(wr_rdy), 1);
    endtask

    task automatic t_unknown();
        wr(16'h0005, 16'h1234);
        chk("R8 strobe", 32'(bad_cmd), 1);
        chk("R8 no reset", 32'({warm_rst, ld_req, id_wr_en}), 0);
        @(negedge clk);
        chk("R8 one cycle", 32'(bad_cmd), 0);
    endtask

    task automatic t_window();
        wr(16'h0200, 16'h00F0);
        chk("R1 below gap", 32'(warm_rst), 0);
        wr(16'h8010, 16'h00F0);
        chk("R1 above win1", 32'(warm_rst), 0);
        wr(16'h800F, 16'h00F0);
        chk("R1 win1 top", 32'(warm_rst), 1);
        wr(16'h01FF, 16'h00F0);
        chk("R1 win0 top", 32'(warm_rst), 1);
    endtask

    task automatic t_load(input logic [15:0] blk, input logic [7:0] pg, input logic [7:0] pg_next);
        blk_addr = blk;
        set_page(pg);
        chk("R11 page set", 32'(page_addr), 32'(pg));
        wr(16'h0000, 16'h00E0);
        chk("R3 armed no req", 32'(ld_req), 0);
        wr(16'h8000, 16'h0000);
        chk("R3 req", 32'(ld_req), 1);
        chk("R5 sector", 32'(ld_sec), exp_sec(blk, pg));
        wr(16'h0000, 16'h00F0);
        chk("R9 stalled write", 32'(warm_rst), 0);
        chk("R9 rdy low", 32'(wr_rdy), 0);
        chk("R3 held", 32'(ld_req), 1);
        chk("R6 no step yet", 32'(page_addr), 32'(pg));
        ack_load();
        chk("R3 released", 32'(ld_req), 0);
        chk("R6 step", 32'(page_addr), 32'(pg_next));
    endtask

    task automatic t_consumed();
        wr(16'h0000, 16'h00E0);
        wr(16'h0000, 16'h0001);
        chk("R4 no load", 32'({ld_req, bad_cmd, warm_rst}), 0);
        wr(16'h0000, 16'h00F0);
        chk("R4 back idle", 32'(warm_rst), 1);
        wr(16'h0000, 16'h00E0);
        wr(16'h4000, 16'h0000);
        chk("R1 miss while armed", 32'(ld_req), 0);
        wr(16'h0100, 16'h0000);
        chk("R1 still armed", 32'(ld_req), 1);
        ack_load();
    endtask

    task automatic t_ident();
        wr(16'h0000, 16'h0090);
        chk("R7 w0 en", 32'({id_wr_en, id_wr_idx}), 32'h4);
        chk("R7 w0 data", 32'(id_wr_data), 32'h00CD);
        chk("R9 rdy low id", 32'(wr_rdy), 0);
        @(negedge clk);
        chk("R7 w1", 32'({id_wr_en, id_wr_idx, id_wr_data}), 32'h50034);
        @(negedge clk);
        chk("R7 w2", 32'({id_wr_en, id_wr_idx, id_wr_data}), 32'h60002);
        @(negedge clk);
        chk("R7 done", 32'({id_wr_en, wr_rdy}), 1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog actual=running expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_warm();
        t_unknown();
        t_window();
        t_load(16'h0005, 8'h13, 8'h17);
        t_load(16'h8003, 8'hFC, 8'h00);
        t_consumed();
        t_ident();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule